// File: doc/BRIEF.md
# Restoring Floating-Point Divider

This block divides one 32-bit floating-point word by another. The format is excess-128 with a hidden leading fraction bit. Bit 31 is the sign. Bits 30:23 hold the biased exponent. Bits 22:0 hold the fraction below an implied leading one, so a value is 0.1fff... times 2 to the power (exponent - 128). An exponent field of zero means the value is zero, whatever the other bits hold.

The quotient is found one bit per clock by a restoring subtract-and-shift loop over the guarded fractions. The loop stops early as soon as the partial remainder becomes zero. The quotient is then normalized by at most one place, rounded or truncated, range-checked and packed.

Operands enter as one beat on a valid/ready channel. The result leaves as one beat on a second valid/ready channel. The input side is ready only while no operation is in flight. A result beat is held with all of its fields stable until the consumer takes it. Back-pressure on the output therefore stalls the input. Each result beat carries:
- the quotient word;
- the N, Z and V condition flags;
- an update flag that tells the host whether to commit the quotient and flags;
- one-bit exception indications for divide-by-zero, overflow and underflow.

Top module: `fdiv_restoring`

## Requirements
- R1: A divisor whose exponent field is zero yields a beat with `out_dz`=1 and `out_upd`=0 (destination and flags are to be left alone), quotient 0, N=Z=V=0 and no overflow or underflow, whatever the dividend is.
- R2: With a non-zero divisor, a dividend whose exponent field is zero yields quotient 0 with Z=1, N=0, V=0, `out_upd`=1 and no exception indications.
- R3: The quotient sign (bit 31) is the XOR of the operand signs, and N equals bit 31 of the delivered quotient.
- R4: The result exponent before normalization is dividend exponent - divisor exponent + 129. When the fraction quotient is below one (its hidden-bit position is 0), it is shifted left once and the exponent is lowered by one.
- R5: With `in_trunc`=0, half a unit of the last fraction place is added at the guard point before the three guard bits are dropped; a carry out of the top renormalizes and raises the exponent by one. With `in_trunc`=1 the guard bits are simply dropped.
- R6: A final exponent above 255 raises `out_ovf` and V=1. If `in_ovf_en`=0 the quotient is forced to 0; otherwise it carries the low 8 bits of the exponent. An exponent of exactly 255 is not an overflow.
- R7: A final exponent of 0 or below raises `out_unf`, with V=0. If `in_unf_en`=0 the quotient is forced to 0; otherwise it carries the low 8 bits of the exponent. An exponent of exactly 1 is not an underflow.
- R8: Z is 1 exactly when the exponent field of the delivered quotient is zero.
- R9: Counting clock edges after the accepting edge, `out_valid` rises at edge k+1, where k is the number of loop steps taken. k is 27 without early exit, or the step after which the remainder became zero. Zero-operand cases (R1, R2) raise `out_valid` at the accepting edge itself.
- R10: `in_ready` is 1 only when no operation is in flight and no result is waiting. While `out_valid`=1 and `out_ready`=0, the result beat holds steady and no new operands are taken.
- R11: After reset, `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Divider can take an operand beat |
| in_dvd | input | 32 | Dividend word |
| in_dvs | input | 32 | Divisor word |
| in_trunc | input | 1 | 1 truncates, 0 rounds |
| in_ovf_en | input | 1 | Overflow trap enabled (keeps wrapped result) |
| in_unf_en | input | 1 | Underflow trap enabled (keeps wrapped result) |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_quo | output | 32 | Quotient word |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_dz | output | 1 | Divide-by-zero indication |
| out_ovf | output | 1 | Overflow indication |
| out_unf | output | 1 | Underflow indication |
| out_upd | output | 1 | Commit quotient and flags |

## Verification
Several properties are checked by the in-line assertions on every cycle:
- the restoring invariant that the partial remainder stays below twice the divisor;
- the bounds of the step counter and the single-cycle completion pulse;
- the stability of a stalled result beat and mutual exclusion of input readiness with a pending result;
- that a divide-by-zero beat never asks for an update and that overflow and underflow never coincide;
- that a zero-exponent result without a range exception is an all-zero word.

Only the bench scenarios can show the arithmetic itself:
- exact and repeating quotients;
- round versus truncate;
- the wrapped-or-zeroed results at each exponent boundary;
- the exact cycle counts with and without early exit.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Per-result status carried with the quotient beat
  typedef struct packed {
    logic upd;   // commit quotient and flags
    logic n;
    logic z;
    logic v;
    logic dz;
    logic ovf;
    logic unf;
  } fdiv_stat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } fdiv_state_t;

endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GUARD  = 3,
  parameter int BIAS   = 128,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAN_W  = FRAC_W + 1 + GUARD,
  localparam int XW     = EXP_W + 2
) (
  input  logic [WORD_W-1:0]    dvd,
  input  logic [WORD_W-1:0]    dvs,
  output logic                 dvd_zero,
  output logic                 dvs_zero,
  output logic                 sign,
  output logic signed [XW-1:0] exp_q,
  output logic [MAN_W-1:0]     man_a,
  output logic [MAN_W-1:0]     man_b
);

  logic [EXP_W-1:0] ea, eb;

  always_comb begin
    ea       = dvd[WORD_W-2 -: EXP_W];
    eb       = dvs[WORD_W-2 -: EXP_W];
    dvd_zero = (ea == '0);
    dvs_zero = (eb == '0);
    sign     = dvd[WORD_W-1] ^ dvs[WORD_W-1];
    // excess-BIAS difference, plus one for the 0.1f fraction convention
    exp_q    = $signed(XW'(ea)) - $signed(XW'(eb)) + $signed(XW'(BIAS + 1));
    man_a    = {1'b1, dvd[FRAC_W-1:0], {GUARD{1'b0}}};
    man_b    = {1'b1, dvs[FRAC_W-1:0], {GUARD{1'b0}}};
  end

endmodule

// File: rtl/fdiv_iter.sv
module fdiv_iter #(
  parameter int MAN_W = 27,
  localparam int CW   = $clog2(MAN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAN_W-1:0] man_a,
  input  logic [MAN_W-1:0] man_b,
  output logic             fin,
  output logic [MAN_W-1:0] quo
);

  logic             busy;
  logic [MAN_W:0]   rem;
  logic [MAN_W-1:0] dvs_r;
  logic [CW-1:0]    cnt;
  logic             ge;
  logic [MAN_W:0]   diff;
  logic [MAN_W-1:0] q_step;

  always_comb begin
    ge     = (rem >= {1'b0, dvs_r});
    diff   = ge ? (rem - {1'b0, dvs_r}) : rem;
    q_step = {quo[MAN_W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      rem   <= '0;
      dvs_r <= '0;
      quo   <= '0;
      cnt   <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        rem   <= {1'b0, man_a};
        dvs_r <= man_b;
        quo   <= '0;
        cnt   <= CW'(MAN_W);
      end else if (busy) begin
        if (cnt == CW'(1)) begin
          quo  <= q_step;
          busy <= 1'b0;
          fin  <= 1'b1;
        end else if (diff == '0) begin
          // remainder exhausted: remaining quotient bits are all zero
          quo  <= q_step << (cnt - CW'(1));
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          quo <= q_step;
          rem <= {diff[MAN_W-1:0], 1'b0};
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  AST_REM_BELOW_TWICE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (rem < {dvs_r, 1'b0})); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt >= CW'(1) && cnt <= CW'(MAN_W))); // R9
  AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin); // R9
  AST_FIN_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(fin) |-> $fell(busy)); // R9

endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GUARD  = 3,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAN_W  = FRAC_W + 1 + GUARD,
  localparam int XW     = EXP_W + 2
) (
  input  logic [MAN_W-1:0]     quo,
  input  logic signed [XW-1:0] exp_in,
  input  logic                 sign,
  input  logic                 trunc,
  input  logic                 ovf_en,
  input  logic                 unf_en,
  output logic [WORD_W-1:0]    word,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_v,
  output logic                 ovf,
  output logic                 unf
);

  localparam logic signed [XW-1:0] EXP_TOP  = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_ZERO = '0;
  localparam logic [MAN_W:0]       RND      = (MAN_W + 1)'(1) << (GUARD - 1);

  logic [MAN_W-1:0]     q_n, q_r;
  logic signed [XW-1:0] e_n, e_r;
  logic [MAN_W:0]       sum;
  logic [WORD_W-1:0]    packed_w;
  logic                 unused_bits;

  always_comb begin
    // single-place normalization
    if (!quo[MAN_W-1]) begin
      q_n = quo << 1;
      e_n = exp_in - $signed(XW'(1));
    end else begin
      q_n = quo;
      e_n = exp_in;
    end
    // round at the guard point
    sum = {1'b0, q_n} + (trunc ? '0 : RND);
    if (sum[MAN_W]) begin
      q_r = sum[MAN_W:1];
      e_r = e_n + $signed(XW'(1));
    end else begin
      q_r = sum[MAN_W-1:0];
      e_r = e_n;
    end
    ovf      = (e_r > EXP_TOP);
    unf      = (e_r <= EXP_ZERO);
    packed_w = {sign, e_r[EXP_W-1:0], q_r[MAN_W-2:GUARD]};
    if ((ovf && !ovf_en) || (unf && !unf_en)) word = '0;
    else                                      word = packed_w;
    flag_n = word[WORD_W-1];
    flag_z = (word[WORD_W-2 -: EXP_W] == '0);
    flag_v = ovf;
  end

  assign unused_bits = ^{q_r[MAN_W-1], q_r[GUARD-1:0]};

endmodule

// File: rtl/fdiv_restoring.sv
module fdiv_restoring #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GUARD  = 3,
  parameter int BIAS   = 128,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_dvd,
  input  logic [WORD_W-1:0] in_dvs,
  input  logic              in_trunc,
  input  logic              in_ovf_en,
  input  logic              in_unf_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_quo,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_dz,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_upd
);
  import fdiv_pkg::*;

  localparam int MAN_W = FRAC_W + 1 + GUARD;
  localparam int XW    = EXP_W + 2;
  localparam int RCW   = $clog2(MAN_W + 2) + 1;

  fdiv_state_t          state;
  fdiv_stat_t           stat_r;
  logic [WORD_W-1:0]    quo_r;
  logic                 sign_r, trunc_r, oe_r, ue_r;
  logic signed [XW-1:0] exp_r;
  logic [RCW-1:0]       run_cyc;

  logic                 dvd_zero, dvs_zero, sign_c;
  logic signed [XW-1:0] exp_c;
  logic [MAN_W-1:0]     man_a, man_b, it_quo;
  logic                 accept, start, it_fin;
  logic [WORD_W-1:0]    pk_word;
  logic                 pk_n, pk_z, pk_v, pk_ovf, pk_unf;

  fdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD(GUARD), .BIAS(BIAS)) u_unpack (
    .dvd(in_dvd), .dvs(in_dvs), .dvd_zero(dvd_zero), .dvs_zero(dvs_zero),
    .sign(sign_c), .exp_q(exp_c), .man_a(man_a), .man_b(man_b));

  fdiv_iter #(.MAN_W(MAN_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .man_a(man_a), .man_b(man_b),
    .fin(it_fin), .quo(it_quo));

  fdiv_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD(GUARD)) u_pack (
    .quo(it_quo), .exp_in(exp_r), .sign(sign_r), .trunc(trunc_r),
    .ovf_en(oe_r), .unf_en(ue_r), .word(pk_word), .flag_n(pk_n), .flag_z(pk_z),
    .flag_v(pk_v), .ovf(pk_ovf), .unf(pk_unf));

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign start    = accept && !dvs_zero && !dvd_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stat_r  <= '0;
      quo_r   <= '0;
      sign_r  <= 1'b0;
      trunc_r <= 1'b0;
      oe_r    <= 1'b0;
      ue_r    <= 1'b0;
      exp_r   <= '0;
      run_cyc <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          sign_r  <= sign_c;
          exp_r   <= exp_c;
          trunc_r <= in_trunc;
          oe_r    <= in_ovf_en;
          ue_r    <= in_unf_en;
          run_cyc <= '0;
          if (dvs_zero) begin
            quo_r  <= '0;
            stat_r <= '{upd: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, dz: 1'b1, ovf: 1'b0, unf: 1'b0};
            state  <= ST_OUT;
          end else if (dvd_zero) begin
            quo_r  <= '0;
            stat_r <= '{upd: 1'b1, n: 1'b0, z: 1'b1, v: 1'b0, dz: 1'b0, ovf: 1'b0, unf: 1'b0};
            state  <= ST_OUT;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          run_cyc <= run_cyc + RCW'(1);
          if (it_fin) begin
            quo_r  <= pk_word;
            stat_r <= '{upd: 1'b1, n: pk_n, z: pk_z, v: pk_v, dz: 1'b0, ovf: pk_ovf, unf: pk_unf};
            state  <= ST_OUT;
          end
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state == ST_OUT);
  assign out_quo   = quo_r;
  assign out_n     = stat_r.n;
  assign out_z     = stat_r.z;
  assign out_v     = stat_r.v;
  assign out_dz    = stat_r.dz;
  assign out_ovf   = stat_r.ovf;
  assign out_unf   = stat_r.unf;
  assign out_upd   = stat_r.upd;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_quo) && $stable(stat_r))); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && out_valid)); // R10
  AST_DZ_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_dz) |-> (!out_upd && out_quo == '0)); // R1
  AST_RANGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_ovf && out_unf)); // R6
  AST_ZERO_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_upd && out_z && !out_ovf && !out_unf) |-> (out_quo == '0)); // R2
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RUN) |-> (run_cyc <= RCW'(MAN_W + 1))); // R9

endmodule

// File: tb/sim_fdiv_restoring.sv
module sim_fdiv_restoring;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dvd = '0, in_dvs = '0;
  logic        in_trunc = 1'b0, in_ovf_en = 1'b0, in_unf_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_quo;
  logic        out_n, out_z, out_v, out_dz, out_ovf, out_unf, out_upd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  fdiv_restoring u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dvd(in_dvd), .in_dvs(in_dvs), .in_trunc(in_trunc), .in_ovf_en(in_ovf_en),
    .in_unf_en(in_unf_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_quo(out_quo), .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_dz(out_dz),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_upd(out_upd));

  // status order: {upd, n, z, v, dz, ovf, unf}; ctl order: {trunc, ovf_en, unf_en}
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  ctl;
    logic [31:0] q;
    logic [6:0]  st;
    logic [7:0]  lat;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h40800000, 32'h40800000, 3'b000, 32'h40800000, 7'b1000000, 8'd2,  8'd4}, // R4 R9 1/1, early exit after step 1
    '{32'h41000000, 32'h40800000, 3'b000, 32'h41000000, 7'b1000000, 8'd2,  8'd4}, // R4 2/1
    '{32'h40800000, 32'h41000000, 3'b000, 32'h40000000, 7'b1000000, 8'd2,  8'd4}, // R4 1/2
    '{32'hC0800000, 32'h40800000, 3'b000, 32'hC0800000, 7'b1100000, 8'd2,  8'd3}, // R3 -1/1
    '{32'hC1400000, 32'hC1000000, 3'b000, 32'h40C00000, 7'b1000000, 8'd3,  8'd3}, // R3 -3/-2, exit after step 2
    '{32'h40800000, 32'h40C00000, 3'b000, 32'h402AAAAB, 7'b1000000, 8'd28, 8'd5}, // R5 1/1.5 rounded, normalized
    '{32'h40800000, 32'h40C00000, 3'b100, 32'h402AAAAA, 7'b1000000, 8'd28, 8'd5}, // R5 1/1.5 truncated
    '{32'hC0800000, 32'h40C00000, 3'b100, 32'hC02AAAAA, 7'b1100000, 8'd28, 8'd3}, // R3 -1/1.5 truncated
    '{32'h7FC00000, 32'h40000000, 3'b010, 32'h00400000, 7'b1011010, 8'd3,  8'd6}, // R6 R8 overflow, trap on: wrapped
    '{32'h7FC00000, 32'h40000000, 3'b000, 32'h00000000, 7'b1011010, 8'd3,  8'd6}, // R6 overflow, trap off: zero
    '{32'h7F800000, 32'h40800000, 3'b000, 32'h7F800000, 7'b1000000, 8'd2,  8'd6}, // R6 exponent 255 boundary
    '{32'h00800000, 32'h7F800000, 3'b001, 32'h41800000, 7'b1000001, 8'd2,  8'd7}, // R7 underflow, trap on: wrapped
    '{32'h00800000, 32'h7F800000, 3'b000, 32'h00000000, 7'b1010001, 8'd2,  8'd7}, // R7 underflow, trap off: zero
    '{32'h00C00000, 32'h41000000, 3'b001, 32'h00400000, 7'b1010001, 8'd3,  8'd7}, // R7 R8 exponent exactly 0
    '{32'h00800000, 32'h40800000, 3'b000, 32'h00800000, 7'b1000000, 8'd2,  8'd7}, // R7 exponent 1 boundary
    '{32'h00123456, 32'h40800000, 3'b000, 32'h00000000, 7'b1010000, 8'd0,  8'd2}, // R2 zero dividend
    '{32'h40800000, 32'h00555555, 3'b000, 32'h00000000, 7'b0000100, 8'd0,  8'd1}, // R1 zero divisor
    '{32'h00000000, 32'h80000000, 3'b011, 32'h00000000, 7'b0000100, 8'd0,  8'd1}  // R1 both zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offer one operand beat; return edges from acceptance to out_valid.
  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [2:0] ctl, output int lat);
    @(negedge clk);
    in_dvd = a; in_dvs = b;
    {in_trunc, in_ovf_en, in_unf_en} = ctl;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].a, VECS[i].b, VECS[i].ctl, lat);
      chk($sformatf("R%0d quotient vec%0d", VECS[i].req, i), out_quo, VECS[i].q);
      chk($sformatf("R%0d status vec%0d", VECS[i].req, i),
          {25'd0, out_upd, out_n, out_z, out_v, out_dz, out_ovf, out_unf}, {25'd0, VECS[i].st});
      chk($sformatf("R9 latency vec%0d", i), lat, {24'd0, VECS[i].lat});
    end

    // R10: stall the output, offer a second beat meanwhile
    @(negedge clk);
    out_ready = 1'b0;
    do_op(32'h40800000, 32'h41000000, 3'b000, lat);
    held = out_quo;
    chk("R10 first result under stall", out_quo, 32'h40000000);
    in_dvd = 32'h41000000; in_dvs = 32'h40800000;
    {in_trunc, in_ovf_en, in_unf_en} = 3'b000;
    in_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 out_valid held", {31'd0, out_valid}, 32'd1);
      chk("R10 quotient stable", out_quo, held);
      chk("R10 in_ready low while pending", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 idle after consume", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk("R10 second beat result", out_quo, 32'h41000000);
    chk("R9 second beat latency", lat, 32'd2);
    @(negedge clk);
    chk("R10 beat consumed", {31'd0, out_valid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule